// File: doc/BRIEF.md
# PCIe BAR Window Region Decoder

This block is an AXI4-Lite slave placed behind a 128 KB PCIe memory window that begins at offset zero. It sorts every single-word access into one of five fixed regions. The lowest region holds the global host-control registers, and the block serves that region itself from a small local register file. The other four regions are the single port's register bank, the received-frame buffer, the command-slot list and the command-table store. Accesses to these four are handed to a downstream request port, which carries a region select and a byte offset relative to the region base.

One transaction is in flight at a time. A write goes ahead only once both its address and its data have been accepted, and these may arrive in either order. The AXI response waits for the downstream acknowledge. An address that falls in none of the five regions is answered with SLVERR and has no side effect.

Top module: `bar_decoder`

## Requirements
- R1: After reset, s_awready, s_wready and s_arready are 1, and s_bvalid, s_rvalid and dn_req are 0.
- R2: The local word offsets 0x04, 0x08 and 0x14–0xFC are read/write. Each byte lane is written only where its strobe bit is 1, and a read returns the stored word with response OKAY (2'b00).
- R3: The local word at 0x00 reads as CAP_VAL with bits [4:0] (the port-count field) forced to zero, 0x0C reads as 0x00000001, and 0x10 reads as VER_VAL. Writes to these three words are answered OKAY and change nothing.
- R4: Forwarded regions raise dn_req with dn_sel and dn_off = (address − base) with bits [1:0] cleared. The regions are: sel 0 = 0x00100–0x0017F, sel 1 = 0x08000–0x080FF, sel 2 = 0x09000–0x093FF, sel 3 = 0x10000–0x1FFFF. A forwarded read returns dn_rdata with OKAY.
- R5: A forwarded write drives dn_we=1 and carries s_wdata and s_wstrb unchanged on dn_wdata and dn_wstrb. A forwarded read drives dn_we=0.
- R6: dn_req and its fields stay stable until dn_ack is seen. The matching s_bvalid or s_rvalid appears only after that acknowledge.
- R7: Any other address (0x00180–0x07FFF, 0x08100–0x08FFF, 0x09400–0x0FFFF) is answered with SLVERR (2'b10), reads return 0, and no downstream request is made.
- R8: The write address and write data may be presented in either order or together. No downstream request and no register update happens before both have been accepted.
- R9: s_bvalid with s_bresp, and s_rvalid with s_rdata and s_rresp, stay stable until the matching ready. Only one response is pending at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| dn_req | output | 1 | Downstream request valid |
| dn_we | output | 1 | Downstream write (1) or read (0) |
| dn_sel | output | 2 | Downstream region select |
| dn_off | output | OFF_W | Byte offset within the region |
| dn_wdata | output | DATA_W | Downstream write data |
| dn_wstrb | output | DATA_W/8 | Downstream byte strobes |
| dn_ack | input | 1 | Downstream acknowledge, one cycle |
| dn_rdata | input | DATA_W | Downstream read data, valid with dn_ack |

## Verification
The bench probes the first and last word of every region and the words just outside them. An off-by-one in a range compare would forward an unmapped word or reject a mapped one, and a wrong base would show up as a wrong dn_off. Writes are sent with address and data separated by several cycles in both orders. A design that dispatched on one channel alone would raise dn_req, or alter a register, before the second channel arrived. The downstream acknowledge is held back for many cycles, and the response ready is withheld. An early response or a drifting response value would then be seen at the ports. Partial strobes on local words and write attempts on the read-only words show up on read-back as wrongly merged bytes or as lost constants.

// File: rtl/bar_dec_pkg.sv
package bar_dec_pkg;

  localparam int WIN_W    = 17;   // decoded window is 2**17 bytes
  localparam int HC_BYTES = 256;  // local host-control region size
  localparam int NFWD     = 4;    // forwarded regions

  // local words with fixed content
  localparam int CAP_IDX = 0;
  localparam int PI_IDX  = 3;
  localparam int VER_IDX = 4;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  typedef enum logic [1:0] {
    FWD_PORT  = 2'd0,
    FWD_RXFIS = 2'd1,
    FWD_CLIST = 2'd2,
    FWD_CTBL  = 2'd3
  } fwd_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LRD,
    ST_DN,
    ST_BRSP,
    ST_RRSP
  } dec_st_e;

  // base of forwarded region i (one bit wider than the window)
  function automatic logic [WIN_W:0] fwd_base(input int i);
    case (i)
      0:       fwd_base = 18'h00100;
      1:       fwd_base = 18'h08000;
      2:       fwd_base = 18'h09000;
      default: fwd_base = 18'h10000;
    endcase
  endfunction

  function automatic logic [WIN_W:0] fwd_size(input int i);
    case (i)
      0:       fwd_size = 18'h00080;
      1:       fwd_size = 18'h00100;
      2:       fwd_size = 18'h00400;
      default: fwd_size = 18'h10000;
    endcase
  endfunction

endpackage

// File: rtl/bar_addr_map.sv
module bar_addr_map
  import bar_dec_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int OFF_W  = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_hc,
  output logic              hit_fwd,
  output logic [1:0]        sel,
  output logic [OFF_W-1:0]  off
);

  logic             in_win;
  logic [WIN_W:0]   low_x;
  logic [NFWD-1:0]  hit_v;
  logic [OFF_W-1:0] rel_v [NFWD];

  // bits above the window must be zero
  generate
    if (ADDR_W > WIN_W) begin : g_hi
      assign in_win = ~|addr[ADDR_W-1:WIN_W];
    end else begin : g_nohi
      assign in_win = 1'b1;
    end
  endgenerate

  assign low_x  = {1'b0, addr[WIN_W-1:0]};
  assign hit_hc = in_win && (low_x < (WIN_W+1)'(HC_BYTES));

  for (genvar i = 0; i < NFWD; i++) begin : g_rgn
    assign hit_v[i] = in_win && (low_x >= fwd_base(i)) &&
                      (low_x < (fwd_base(i) + fwd_size(i)));
    assign rel_v[i] = OFF_W'(low_x - fwd_base(i));
  end

  always_comb begin
    hit_fwd = 1'b0;
    sel     = 2'd0;
    off     = '0;
    for (int i = 0; i < NFWD; i++) begin
      if (hit_v[i]) begin
        hit_fwd = 1'b1;
        sel     = 2'(i);
        off     = rel_v[i] & ~(OFF_W'(3));
      end
    end
  end

endmodule

// File: rtl/bar_host_regs.sv
module bar_host_regs
  import bar_dec_pkg::*;
#(
  parameter int          WORDS   = 64,
  parameter int          DATA_W  = 32,
  parameter logic [31:0] CAP_VAL = 32'h4031_FF1F,
  parameter logic [31:0] VER_VAL = 32'h0001_0301
) (
  input  logic                       clk,
  input  logic                       wr_en,
  input  logic [$clog2(WORDS)-1:0]   wr_idx,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [DATA_W/8-1:0]        wr_strb,
  input  logic                       rd_en,
  input  logic [$clog2(WORDS)-1:0]   rd_idx,
  output logic [DATA_W-1:0]          rd_data
);

  localparam int IDX_W = $clog2(WORDS);
  localparam int NB    = DATA_W / 8;

  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] ram_q;
  logic [IDX_W-1:0]  idx_q;
  logic              wr_ro;

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = '0;
  end

  assign wr_ro = (wr_idx == IDX_W'(CAP_IDX)) || (wr_idx == IDX_W'(PI_IDX)) ||
                 (wr_idx == IDX_W'(VER_IDX));

  // byte-lane writes, one process per lane
  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (wr_en && !wr_ro && wr_strb[b]) begin
        mem[wr_idx][b*8 +: 8] <= wr_data[b*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      ram_q <= mem[rd_idx];
      idx_q <= rd_idx;
    end
  end

  // fixed words overlay the stored contents
  always_comb begin
    case (idx_q)
      IDX_W'(CAP_IDX): rd_data = {CAP_VAL[DATA_W-1:5], 5'd0};
      IDX_W'(PI_IDX):  rd_data = DATA_W'(1);
      IDX_W'(VER_IDX): rd_data = VER_VAL[DATA_W-1:0];
      default:         rd_data = ram_q;
    endcase
  end

endmodule

// File: rtl/bar_decoder.sv
module bar_decoder
  import bar_dec_pkg::*;
#(
  parameter int          ADDR_W  = 17,
  parameter int          DATA_W  = 32,
  parameter int          OFF_W   = 16,
  parameter logic [31:0] CAP_VAL = 32'h4031_FF1F,
  parameter logic [31:0] VER_VAL = 32'h0001_0301
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     s_awaddr,
  input  logic                  s_awvalid,
  output logic                  s_awready,
  input  logic [DATA_W-1:0]     s_wdata,
  input  logic [DATA_W/8-1:0]   s_wstrb,
  input  logic                  s_wvalid,
  output logic                  s_wready,
  output logic [1:0]            s_bresp,
  output logic                  s_bvalid,
  input  logic                  s_bready,
  input  logic [ADDR_W-1:0]     s_araddr,
  input  logic                  s_arvalid,
  output logic                  s_arready,
  output logic [DATA_W-1:0]     s_rdata,
  output logic [1:0]            s_rresp,
  output logic                  s_rvalid,
  input  logic                  s_rready,
  output logic                  dn_req,
  output logic                  dn_we,
  output logic [1:0]            dn_sel,
  output logic [OFF_W-1:0]      dn_off,
  output logic [DATA_W-1:0]     dn_wdata,
  output logic [DATA_W/8-1:0]   dn_wstrb,
  input  logic                  dn_ack,
  input  logic [DATA_W-1:0]     dn_rdata
);

  localparam int STRB_W   = DATA_W / 8;
  localparam int HC_WORDS = HC_BYTES / STRB_W;
  localparam int HC_IDX_W = $clog2(HC_WORDS);

  dec_st_e             st;
  logic                aw_held, w_held;
  logic [ADDR_W-1:0]   aw_addr_q;
  logic [DATA_W-1:0]   w_data_q;
  logic [STRB_W-1:0]   w_strb_q;

  logic                wr_hit_hc, wr_hit_fwd, rd_hit_hc, rd_hit_fwd;
  logic [1:0]          wr_sel, rd_sel;
  logic [OFF_W-1:0]    wr_off, rd_off;
  logic                wr_go, rd_go;
  logic                hc_wr_en, hc_rd_en;
  logic [DATA_W-1:0]   hc_rd_data;

  bar_addr_map #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_map_wr (
    .addr    (aw_addr_q),
    .hit_hc  (wr_hit_hc),
    .hit_fwd (wr_hit_fwd),
    .sel     (wr_sel),
    .off     (wr_off)
  );

  bar_addr_map #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_map_rd (
    .addr    (s_araddr),
    .hit_hc  (rd_hit_hc),
    .hit_fwd (rd_hit_fwd),
    .sel     (rd_sel),
    .off     (rd_off)
  );

  // a complete write wins over a waiting read
  assign wr_go     = (st == ST_IDLE) && aw_held && w_held;
  assign s_arready = (st == ST_IDLE) && !(aw_held && w_held);
  assign rd_go     = s_arready && s_arvalid;
  assign s_awready = !aw_held;
  assign s_wready  = !w_held;
  assign s_bvalid  = (st == ST_BRSP);
  assign s_rvalid  = (st == ST_RRSP);

  assign hc_wr_en = wr_go && wr_hit_hc;
  assign hc_rd_en = rd_go && rd_hit_hc;

  bar_host_regs #(
    .WORDS   (HC_WORDS),
    .DATA_W  (DATA_W),
    .CAP_VAL (CAP_VAL),
    .VER_VAL (VER_VAL)
  ) i_regs (
    .clk     (clk),
    .wr_en   (hc_wr_en),
    .wr_idx  (aw_addr_q[HC_IDX_W+1:2]),
    .wr_data (w_data_q),
    .wr_strb (w_strb_q),
    .rd_en   (hc_rd_en),
    .rd_idx  (s_araddr[HC_IDX_W+1:2]),
    .rd_data (hc_rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      aw_held   <= 1'b0;
      w_held    <= 1'b0;
      aw_addr_q <= '0;
      w_data_q  <= '0;
      w_strb_q  <= '0;
      s_bresp   <= RESP_OKAY;
      s_rresp   <= RESP_OKAY;
      s_rdata   <= '0;
      dn_req    <= 1'b0;
      dn_we     <= 1'b0;
      dn_sel    <= 2'd0;
      dn_off    <= '0;
      dn_wdata  <= '0;
      dn_wstrb  <= '0;
    end else begin
      if (s_awvalid && s_awready) begin
        aw_held   <= 1'b1;
        aw_addr_q <= s_awaddr;
      end
      if (s_wvalid && s_wready) begin
        w_held   <= 1'b1;
        w_data_q <= s_wdata;
        w_strb_q <= s_wstrb;
      end

      case (st)
        ST_IDLE: begin
          if (wr_go) begin
            aw_held <= 1'b0;
            w_held  <= 1'b0;
            if (wr_hit_hc) begin
              s_bresp <= RESP_OKAY;
              st      <= ST_BRSP;
            end else if (wr_hit_fwd) begin
              dn_req   <= 1'b1;
              dn_we    <= 1'b1;
              dn_sel   <= wr_sel;
              dn_off   <= wr_off;
              dn_wdata <= w_data_q;
              dn_wstrb <= w_strb_q;
              st       <= ST_DN;
            end else begin
              s_bresp <= RESP_SLVERR;
              st      <= ST_BRSP;
            end
          end else if (rd_go) begin
            if (rd_hit_hc) begin
              st <= ST_LRD;
            end else if (rd_hit_fwd) begin
              dn_req   <= 1'b1;
              dn_we    <= 1'b0;
              dn_sel   <= rd_sel;
              dn_off   <= rd_off;
              dn_wdata <= '0;
              dn_wstrb <= '0;
              st       <= ST_DN;
            end else begin
              s_rdata <= '0;
              s_rresp <= RESP_SLVERR;
              st      <= ST_RRSP;
            end
          end
        end
        ST_LRD: begin
          s_rdata <= hc_rd_data;
          s_rresp <= RESP_OKAY;
          st      <= ST_RRSP;
        end
        ST_DN: begin
          if (dn_ack) begin
            dn_req <= 1'b0;
            if (dn_we) begin
              s_bresp <= RESP_OKAY;
              st      <= ST_BRSP;
            end else begin
              s_rdata <= dn_rdata;
              s_rresp <= RESP_OKAY;
              st      <= ST_RRSP;
            end
          end
        end
        ST_BRSP: if (s_bready) st <= ST_IDLE;
        ST_RRSP: if (s_rready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bar_decoder_chk.sv
module bar_decoder_chk #(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16
) (
  input logic                clk,
  input logic                rst,
  input logic [1:0]          s_bresp,
  input logic                s_bvalid,
  input logic                s_bready,
  input logic [DATA_W-1:0]   s_rdata,
  input logic [1:0]          s_rresp,
  input logic                s_rvalid,
  input logic                s_rready,
  input logic                dn_req,
  input logic                dn_we,
  input logic [1:0]          dn_sel,
  input logic [OFF_W-1:0]    dn_off,
  input logic [DATA_W-1:0]   dn_wdata,
  input logic [DATA_W/8-1:0] dn_wstrb,
  input logic                dn_ack
);

  // R6
  dn_hold_chk: assert property (@(posedge clk) disable iff (rst)
    dn_req && !dn_ack |=> dn_req && $stable(dn_we) && $stable(dn_sel) &&
      $stable(dn_off) && $stable(dn_wdata) && $stable(dn_wstrb));

  // R6
  dn_no_resp_chk: assert property (@(posedge clk) disable iff (rst)
    dn_req |-> !s_bvalid && !s_rvalid);

  // R9
  b_hold_chk: assert property (@(posedge clk) disable iff (rst)
    s_bvalid && !s_bready |=> s_bvalid && $stable(s_bresp));

  // R9
  r_hold_chk: assert property (@(posedge clk) disable iff (rst)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata) && $stable(s_rresp));

  // R9
  one_resp_chk: assert property (@(posedge clk) disable iff (rst)
    !(s_bvalid && s_rvalid));

  // R7
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    s_rvalid && (s_rresp == 2'b10) |-> (s_rdata == '0));

  // R4
  dn_align_chk: assert property (@(posedge clk) disable iff (rst)
    dn_req |-> (dn_off[1:0] == 2'b00));

endmodule

bind bar_decoder bar_decoder_chk #(.DATA_W(DATA_W), .OFF_W(OFF_W)) i_chk (.*);

// File: tb/test_bar_decoder.sv
`timescale 1ns/1ps
module test_bar_decoder;

  localparam logic [31:0] CAPV = 32'h4031_FF1F;
  localparam logic [31:0] VERV = 32'h0001_0301;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [16:0] s_awaddr = '0, s_araddr = '0;
  logic        s_awvalid = 1'b0, s_wvalid = 1'b0, s_bready = 1'b0;
  logic        s_arvalid = 1'b0, s_rready = 1'b0;
  logic [31:0] s_wdata = '0;
  logic [3:0]  s_wstrb = '0;
  logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0]  s_bresp, s_rresp;
  logic [31:0] s_rdata;
  logic        dn_req, dn_we;
  logic [1:0]  dn_sel;
  logic [15:0] dn_off;
  logic [31:0] dn_wdata;
  logic [3:0]  dn_wstrb;
  logic        dn_ack = 1'b0;
  logic [31:0] dn_rdata = '0;

  int total = 0, bad = 0;
  int cyc_cnt = 0, ack_cyc = 0, req_count = 0, force_delay = -1;
  logic        last_we;
  logic [1:0]  last_sel;
  logic [15:0] last_off;
  logic [31:0] last_wdata;
  logic [3:0]  last_wstrb;
  logic [31:0] mirror [64];

  bar_decoder #(.CAP_VAL(CAPV), .VER_VAL(VERV)) i_bar_decoder (.*);

  always #2 clk = ~clk;
  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  function automatic logic [31:0] dn_val(input logic [1:0] sel, input logic [15:0] off);
    return {6'h2A, sel, 8'h5C, off};
  endfunction

  // 0 local, 1 forwarded, 2 unmapped
  function automatic int exp_region(input logic [16:0] a, output logic [1:0] sel,
                                    output logic [15:0] off);
    sel = 0; off = 0;
    if (a < 17'h100) return 0;
    if (a >= 17'h100 && a < 17'h180) begin sel = 0; off = 16'(a - 17'h100); end
    else if (a >= 17'h8000 && a < 17'h8100) begin sel = 1; off = 16'(a - 17'h8000); end
    else if (a >= 17'h9000 && a < 17'h9400) begin sel = 2; off = 16'(a - 17'h9000); end
    else if (a >= 17'h10000) begin sel = 3; off = 16'(a - 17'h10000); end
    else return 2;
    off[1:0] = 2'b00;
    return 1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  initial begin
    dn_ack = 0;
    forever begin
      @(negedge clk);
      if (dn_req && !rst) begin
        int d;
        req_count++;
        last_we = dn_we; last_sel = dn_sel; last_off = dn_off;
        last_wdata = dn_wdata; last_wstrb = dn_wstrb;
        d = (force_delay >= 0) ? force_delay : int'($urandom % 4);
        repeat (d) @(negedge clk);
        dn_ack = 1; dn_rdata = dn_val(dn_sel, dn_off); ack_cyc = cyc_cnt;
        @(negedge clk);
        dn_ack = 0;
      end
    end
  end

  task automatic do_wr(input logic [16:0] a, input logic [31:0] d, input logic [3:0] sb,
                       input int awd, input int wd, input int bd,
                       output logic [1:0] resp, output bit early, output int bcyc);
    bit aw_done = 0, w_done = 0, hs_aw, hs_w;
    int c = 0;
    early = 0;
    while (!(aw_done && w_done)) begin
      if (!aw_done && c >= awd) begin s_awvalid = 1; s_awaddr = a; end
      if (!w_done && c >= wd) begin s_wvalid = 1; s_wdata = d; s_wstrb = sb; end
      hs_aw = s_awvalid && s_awready;
      hs_w  = s_wvalid && s_wready;
      if (dn_req || s_bvalid) early = 1;
      @(negedge clk);
      if (hs_aw) begin aw_done = 1; s_awvalid = 0; end
      if (hs_w) begin w_done = 1; s_wvalid = 0; end
      c++;
    end
    while (!s_bvalid) @(negedge clk);
    bcyc = cyc_cnt;
    resp = s_bresp;
    if (bd > 0) begin
      repeat (bd) @(negedge clk);
      chk(s_bvalid && s_bresp == resp, "R9 bvalid hold", {s_bvalid, s_bresp}, {1'b1, resp});
    end
    s_bready = 1;
    @(negedge clk);
    s_bready = 0;
  endtask

  task automatic do_rd(input logic [16:0] a, input int rdly,
                       output logic [31:0] data, output logic [1:0] resp);
    bit hs;
    s_arvalid = 1; s_araddr = a;
    do begin
      hs = s_arready;
      @(negedge clk);
    end while (!hs);
    s_arvalid = 0;
    while (!s_rvalid) @(negedge clk);
    data = s_rdata; resp = s_rresp;
    if (rdly > 0) begin
      repeat (rdly) @(negedge clk);
      chk(s_rvalid && s_rdata == data && s_rresp == resp, "R9 rvalid hold", s_rdata, data);
    end
    s_rready = 1;
    @(negedge clk);
    s_rready = 0;
  endtask

  function automatic logic [31:0] local_exp(input int idx);
    if (idx == 0) return {CAPV[31:5], 5'd0};
    if (idx == 3) return 32'h1;
    if (idx == 4) return VERV;
    return mirror[idx];
  endfunction

  // full checked access against the bench model
  task automatic access(input bit wr, input logic [16:0] a, input logic [31:0] d,
                        input logic [3:0] sb, input int awd, input int wd, input int hd);
    logic [1:0] sel, resp; logic [15:0] off; logic [31:0] data;
    bit early; int bcyc, kind, rc0;
    kind = exp_region(a, sel, off);
    rc0 = req_count;
    if (wr) begin
      do_wr(a, d, sb, awd, wd, hd, resp, early, bcyc);
      chk(!early, "R8 no early dispatch", 32'(early), 0);
      if (kind == 0) begin
        int idx = int'(a[7:2]);
        chk(resp == 2'b00, "R2 local bresp", 32'(resp), 0);
        if (idx != 0 && idx != 3 && idx != 4)
          for (int b = 0; b < 4; b++) if (sb[b]) mirror[idx][b*8 +: 8] = d[b*8 +: 8];
      end else if (kind == 1) begin
        chk(resp == 2'b00 && req_count == rc0 + 1, "R4 fwd write resp", 32'(resp), 0);
        chk(last_we && last_sel == sel && last_off == off, "R4 fwd write sel/off",
            {last_we, 13'd0, last_sel, last_off}, {1'b1, 13'd0, sel, off});
        chk(last_wdata == d && last_wstrb == sb, "R5 fwd wdata/wstrb", last_wdata, d);
      end else begin
        chk(resp == 2'b10, "R7 unmapped bresp", 32'(resp), 2);
        chk(req_count == rc0, "R7 unmapped write no request", req_count, rc0);
      end
    end else begin
      do_rd(a, hd, data, resp);
      if (kind == 0) begin
        chk(resp == 2'b00 && data == local_exp(int'(a[7:2])), "R2 R3 local read",
            data, local_exp(int'(a[7:2])));
      end else if (kind == 1) begin
        chk(resp == 2'b00 && data == dn_val(sel, off), "R4 fwd read data", data, dn_val(sel, off));
        chk(!last_we && last_sel == sel && last_off == off, "R5 fwd read we=0",
            {last_we, 13'd0, last_sel, last_off}, {1'b0, 13'd0, sel, off});
      end else begin
        chk(resp == 2'b10 && data == 0 && req_count == rc0, "R7 unmapped read", data, 0);
      end
    end
  endtask

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [1:0] resp; bit early; int bcyc;
    void'($urandom(32'd2718));
    for (int i = 0; i < 64; i++) mirror[i] = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk(s_awready && s_wready && s_arready && !s_bvalid && !s_rvalid && !dn_req,
        "R1 reset state", {s_awready, s_wready, s_arready, s_bvalid, s_rvalid, dn_req}, 6'b111000);

    // R3 fixed words, then attempts to overwrite them
    access(0, 17'h00000, 0, 0, 0, 0, 0);
    access(0, 17'h0000C, 0, 0, 0, 0, 0);
    access(0, 17'h00010, 0, 0, 0, 0, 0);
    access(1, 17'h00000, 32'hFFFF_FFFF, 4'hF, 0, 0, 0);
    access(1, 17'h0000C, 32'hFFFF_FFFF, 4'hF, 0, 0, 0);
    access(0, 17'h00000, 0, 0, 0, 0, 0);
    access(0, 17'h0000C, 0, 0, 0, 0, 0);

    // R2 full and partial strobes
    access(1, 17'h00004, 32'h1234_5678, 4'hF, 0, 0, 0);
    access(0, 17'h00004, 0, 0, 0, 0, 0);
    access(1, 17'h00004, 32'hAABB_CCDD, 4'b0101, 0, 0, 0);
    access(0, 17'h00004, 0, 0, 0, 0, 0);
    access(1, 17'h000FC, 32'hCAFE_F00D, 4'b1000, 0, 0, 0);
    access(0, 17'h000FC, 0, 0, 0, 0, 0);

    // R4 R5 region edges, R7 neighbours
    for (int k = 0; k < 2; k++) begin
      access(k, 17'h00100, 32'h0101_0101, 4'b0011, 0, 0, 0);
      access(k, 17'h0017C, 32'h0202_0202, 4'hF, 0, 0, 0);
      access(k, 17'h08000, 32'h0303_0303, 4'b1100, 0, 0, 0);
      access(k, 17'h080FC, 32'h0404_0404, 4'h0, 0, 0, 0);
      access(k, 17'h09000, 32'h0505_0505, 4'hF, 0, 0, 0);
      access(k, 17'h093FC, 32'h0606_0606, 4'h1, 0, 0, 0);
      access(k, 17'h10000, 32'h0707_0707, 4'hF, 0, 0, 0);
      access(k, 17'h1FFFF, 32'h0808_0808, 4'h8, 0, 0, 0);
      access(k, 17'h00180, 32'h0909_0909, 4'hF, 0, 0, 0);
      access(k, 17'h07FFC, 32'h0A0A_0A0A, 4'hF, 0, 0, 0);
      access(k, 17'h08100, 32'h0B0B_0B0B, 4'hF, 0, 0, 0);
      access(k, 17'h08FFC, 32'h0C0C_0C0C, 4'hF, 0, 0, 0);
      access(k, 17'h09400, 32'h0D0D_0D0D, 4'hF, 0, 0, 0);
      access(k, 17'h0FFFC, 32'h0E0E_0E0E, 4'hF, 0, 0, 0);
    end

    // R8 channel order, both local and forwarded
    access(1, 17'h09010, 32'hDEAD_BEEF, 4'hF, 0, 6, 0);
    access(1, 17'h09014, 32'hBEEF_DEAD, 4'hF, 6, 0, 0);
    access(1, 17'h00008, 32'h5555_AAAA, 4'hF, 5, 0, 0);
    access(1, 17'h00008, 32'h0F0F_0F0F, 4'b0110, 0, 5, 0);
    access(0, 17'h00008, 0, 0, 0, 0, 0);

    // R6 slow acknowledge, R9 slow ready
    force_delay = 9;
    do_wr(17'h08040, 32'h1357_9BDF, 4'hF, 0, 0, 3, resp, early, bcyc);
    chk(bcyc > ack_cyc, "R6 bvalid after ack", bcyc, ack_cyc + 1);
    access(0, 17'h10400, 0, 0, 0, 0, 4);
    force_delay = -1;

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [16:0] a; int r = int'($urandom % 4);
      case (r)
        0: a = 17'($urandom % 64) << 2;
        1: begin
          int g = int'($urandom % 4);
          logic [16:0] bs [4] = '{17'h100, 17'h8000, 17'h9000, 17'h10000};
          int sz [4] = '{32'h80, 32'h100, 32'h400, 32'h10000};
          a = bs[g] + 17'($urandom % sz[g]);
        end
        2: begin
          int g = int'($urandom % 3);
          if (g == 0) a = 17'h180 + 17'($urandom % (32'h8000 - 32'h180));
          else if (g == 1) a = 17'h8100 + 17'($urandom % 32'hF00);
          else a = 17'h9400 + 17'($urandom % (32'h10000 - 32'h9400));
        end
        default: a = 17'($urandom);
      endcase
      access(bit'($urandom % 2), a, $urandom, 4'($urandom), int'($urandom % 4),
             int'($urandom % 4), int'($urandom % 3));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule